// File: doc/BRIEF.md
# Timestamp-Ordered Stream Merger

This block joins several input streams into one output stream while keeping the merged output in time order. Each input carries a timestamp, a payload word and an end-of-stream flag on a valid/ready handshake. Each input is assumed to arrive already sorted by timestamp. In any cycle the block accepts at most one word. That word comes from the input whose waiting word carries the oldest timestamp. The accepted word is copied into an output register, which offers it downstream on its own valid/ready handshake.

An older word can only be overlooked if its input has not yet presented it. To prevent this, the block accepts nothing until every input either has a word waiting or has already delivered its final word. An input that has delivered its final word is taken out of the merge. It then neither blocks the others nor receives ready, until the next reset.

The choice of input is made by a balanced tree of timestamp comparators with depth log2 of the input count. Only the output register sits after the tree. Input count, timestamp width and payload width are parameters.

Top module: `ts_merge_arbiter`

## Requirements
- R1: While `rst` is high, every bit of `in_ready` is 0, even when inputs are valid. The first cycle after reset shows `out_valid` = 0, and every input counts as unfinished again.
- R2: At most one bit of `in_ready` is 1 in any cycle. A word is transferred from input i exactly when `in_valid[i]` and `in_ready[i]` are both 1 at a clock edge.
- R3: Among the inputs that have a word waiting and are not finished, the one with the numerically smallest `in_ts` slice is granted. Input i's timestamp is bits [i*TS_W +: TS_W] of `in_ts`, and its payload is bits [i*DATA_W +: DATA_W] of `in_data`. On equal timestamps the lowest input index wins.
- R4: When every input is sorted non-decreasing, the sequence of accepted output timestamps is non-decreasing.
- R5: No input is granted while any unfinished input has `in_valid` = 0.
- R6: A transfer with `in_last[i]` = 1 marks input i finished. After that, its `in_valid`, `in_ts` and `in_data` are ignored, it never sees `in_ready`, and it no longer holds back a grant.
- R7: A word granted at a clock edge is on the outputs in the following cycle with `out_valid` = 1. `out_ts` and `out_data` then carry its timestamp and payload, `out_ch` carries its input index, and `out_last` carries its end flag. Every input word appears exactly once.
- R8: A grant needs the output register to be free, meaning `out_valid` = 0 or `out_ready` = 1. While `out_valid` = 1 and `out_ready` = 0, all `in_ready` bits are 0 and the output fields hold steady.
- R9: When the held word is accepted (`out_valid` and `out_ready` both 1) and nothing is granted in that cycle, `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NUM_CH | Word waiting on input i |
| in_ready | output | NUM_CH | Word on input i is taken at this edge |
| in_ts | input | NUM_CH*TS_W | Timestamps, input i at [i*TS_W +: TS_W] |
| in_data | input | NUM_CH*DATA_W | Payloads, input i at [i*DATA_W +: DATA_W] |
| in_last | input | NUM_CH | Word is the final one of input i |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Downstream takes the held word |
| out_ts | output | TS_W | Timestamp of the held word |
| out_data | output | DATA_W | Payload of the held word |
| out_ch | output | max(1,clog2(NUM_CH)) | Input index the held word came from |
| out_last | output | 1 | Held word was its input's final word |

## Verification
The bench drives timestamp ties both across inputs and within one input. A design that resolves a tie toward the higher index, or uses a non-strict compare in its tree, emits the wrong `out_ch` and payload.

In one scenario a lagging input goes silent while the others hold older and newer words. A block that grants without waiting for every input would send a word out of time order.

Finished inputs keep asserting valid with timestamp zero. A block that does not retire inputs would pick that junk word, or stall forever on an input that has ended.

The bench also toggles `out_ready` against the grants. An output register that drops or overwrites a held word loses or duplicates data, and that shows up in the per-cycle comparison and in the word count.

// File: rtl/ts_merge_pkg.sv
`timescale 1ns/1ps
package ts_merge_pkg;

  // Width of a channel index; never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Leaf count of the comparator tree: channel count rounded up to 2^k.
  function automatic int leaf_count(input int n);
    int levels;
    levels = (n > 1) ? $clog2(n) : 0;
    return 1 << levels;
  endfunction

  // Tree node rule: the right (higher index) side wins only if it is live
  // and strictly older, so equal stamps resolve to the lower index.
  function automatic logic prefer_right(input logic left_live,
                                        input logic right_live,
                                        input logic right_older);
    return right_live && (!left_live || right_older);
  endfunction

endpackage

// File: rtl/ts_merge_tracker.sv
`timescale 1ns/1ps
module ts_merge_tracker #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] in_valid,
  input  logic [NUM_CH-1:0] in_last,
  input  logic [NUM_CH-1:0] in_ready,
  output logic [NUM_CH-1:0] live,
  output logic              eligible
);

  logic [NUM_CH-1:0] done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
    end else begin
      done_q <= done_q | (in_valid & in_ready & in_last);
    end
  end

  assign live     = in_valid & ~done_q;
  assign eligible = &(in_valid | done_q);

  // R6: a retired channel is never handed ready
  a_r6_no_ready_when_done: assert property (@(posedge clk) disable iff (rst)
    (in_ready & done_q) == '0);

  // R6: retirement stays in force until reset
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q & $past(done_q)) == $past(done_q));

  // R5: any ready implies every channel was present or retired
  a_r5_wait_for_all: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> &(in_valid | done_q));

endmodule

// File: rtl/ts_min_tree.sv
`timescale 1ns/1ps
module ts_min_tree #(
  parameter int NUM_CH = 4,
  parameter int TS_W   = 16,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0]      leaf_valid,
  input  logic [NUM_CH*TS_W-1:0] leaf_ts,
  output logic                   root_valid,
  output logic [TS_W-1:0]        root_ts,
  output logic [IDX_W-1:0]       root_idx
);

  localparam int LEAVES = ts_merge_pkg::leaf_count(NUM_CH);
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node k has children 2k and 2k+1, leaves at LEAVES..NODES.
  logic             node_v   [1:NODES];
  logic [TS_W-1:0]  node_ts  [1:NODES];
  logic [IDX_W-1:0] node_idx [1:NODES];

  genvar i, k;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_CH) begin : g_real
        assign node_v[LEAVES+i]  = leaf_valid[i];
        assign node_ts[LEAVES+i] = leaf_ts[i*TS_W +: TS_W];
      end else begin : g_pad
        assign node_v[LEAVES+i]  = 1'b0;
        assign node_ts[LEAVES+i] = '0;
      end
      assign node_idx[LEAVES+i] = IDX_W'(i);
    end

    for (k = 1; k < LEAVES; k++) begin : g_node
      logic take_r;
      assign take_r = ts_merge_pkg::prefer_right(node_v[2*k], node_v[2*k+1],
                                                 node_ts[2*k+1] < node_ts[2*k]);
      assign node_v[k]   = node_v[2*k] | node_v[2*k+1];
      assign node_ts[k]  = take_r ? node_ts[2*k+1]  : node_ts[2*k];
      assign node_idx[k] = take_r ? node_idx[2*k+1] : node_idx[2*k];
    end
  endgenerate

  assign root_valid = node_v[1];
  assign root_ts    = node_ts[1];
  assign root_idx   = node_idx[1];

endmodule

// File: rtl/ts_merge_outreg.sv
`timescale 1ns/1ps
module ts_merge_outreg #(
  parameter int TS_W   = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TS_W-1:0]   ld_ts,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_last,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [TS_W-1:0]   out_ts,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_ch,
  output logic              out_last
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_ts   <= ld_ts;
      out_data <= ld_data;
      out_ch   <= ld_idx;
      out_last <= ld_last;
    end
  end

  // R8: a stalled word stays put
  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ts) && $stable(out_data)
                                && $stable(out_ch) && $stable(out_last));

  // R9: an accepted word with nothing behind it empties the register
  a_r9_drain: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !load |=> !out_valid);

endmodule

// File: rtl/ts_merge_arbiter.sv
`timescale 1ns/1ps
module ts_merge_arbiter #(
  parameter int NUM_CH = 4,
  parameter int TS_W   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = ts_merge_pkg::idx_width(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        in_valid,
  output logic [NUM_CH-1:0]        in_ready,
  input  logic [NUM_CH*TS_W-1:0]   in_ts,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  input  logic [NUM_CH-1:0]        in_last,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [TS_W-1:0]          out_ts,
  output logic [DATA_W-1:0]        out_data,
  output logic [IDX_W-1:0]         out_ch,
  output logic                     out_last
);

  logic [NUM_CH-1:0] live;
  logic              eligible;
  logic              win_valid;
  logic [TS_W-1:0]   win_ts;
  logic [IDX_W-1:0]  win_idx;
  logic              slot_free;
  logic              fire;
  logic [DATA_W-1:0] win_data;
  logic              win_last;

  ts_merge_tracker #(.NUM_CH(NUM_CH)) u_track (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .live     (live),
    .eligible (eligible)
  );

  ts_min_tree #(.NUM_CH(NUM_CH), .TS_W(TS_W), .IDX_W(IDX_W)) u_tree (
    .leaf_valid (live),
    .leaf_ts    (in_ts),
    .root_valid (win_valid),
    .root_ts    (win_ts),
    .root_idx   (win_idx)
  );

  assign fire     = !rst && eligible && win_valid && slot_free;
  assign in_ready = fire ? (NUM_CH'(1) << win_idx) : '0;
  assign win_data = in_data[win_idx*DATA_W +: DATA_W];
  assign win_last = in_last[win_idx];

  ts_merge_outreg #(.TS_W(TS_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (fire),
    .ld_ts     (win_ts),
    .ld_data   (win_data),
    .ld_idx    (win_idx),
    .ld_last   (win_last),
    .out_ready (out_ready),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_ts    (out_ts),
    .out_data  (out_data),
    .out_ch    (out_ch),
    .out_last  (out_last)
  );

  // Checking state: last timestamp accepted downstream.
  logic [TS_W-1:0] chk_prev_ts;
  logic            chk_prev_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_prev_ok <= 1'b0;
      chk_prev_ts <= '0;
    end else if (out_valid && out_ready) begin
      chk_prev_ok <= 1'b1;
      chk_prev_ts <= out_ts;
    end
  end

  // R2: one grant at most
  a_r2_onehot_ready: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  // R8: a stalled output blocks every input
  a_r8_no_grant_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> in_ready == '0);

  // R7: the word shown next cycle names the channel that was ready
  a_r7_word_follows: assert property (@(posedge clk) disable iff (rst)
    |(in_valid & in_ready) |=> out_valid && (($past(in_ready) >> out_ch) == NUM_CH'(1)));

  // R4: output time never steps backwards (inputs sorted)
  a_r4_monotonic: assert property (@(posedge clk) disable iff (rst)
    out_valid && chk_prev_ok |-> out_ts >= chk_prev_ts);

endmodule

// File: tb/tb_ts_merge_arbiter.sv
`timescale 1ns/1ps
module tb_ts_merge_arbiter;

  localparam int N  = 4;
  localparam int TW = 16;
  localparam int DW = 16;
  localparam int MAXW = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N*TW-1:0] in_ts = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    in_last = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [TW-1:0]   out_ts;
  logic [DW-1:0]   out_data;
  logic [1:0]      out_ch;
  logic            out_last;

  ts_merge_arbiter #(.NUM_CH(N), .TS_W(TW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts),
    .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_ts(out_ts),
    .out_data(out_data), .out_ch(out_ch), .out_last(out_last)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  // Stimulus store and reference state
  int wts [N][MAXW];
  int len [N];
  int ptr [N];
  bit m_done [N];
  bit m_ov;
  int m_ts, m_data, m_ch;
  bit m_last;
  bit dv [N];
  int dts [N];
  int ddata [N];
  bit dlast [N];
  int acc_count, total;
  int last_acc;
  bit have_acc;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit gate(input int sc, input int c, input int cyc);
    case (sc)
      1: return ((cyc + c * 3) % 5) != 0;
      3: return !(c == 3 && cyc >= 3 && cyc <= 12);
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit rdy_pat(input int sc, input int cyc);
    case (sc)
      1: return ((cyc * 5) % 7) < 4;
      2: return (cyc % 2) == 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic fill(input int sc);
    total = 0;
    for (int c = 0; c < N; c++) begin
      int t;
      case (sc)
        1: len[c] = 5 + c * 3;
        2: len[c] = 6;
        3: len[c] = (c == 0) ? 1 : (c == 1) ? 2 : 10;
        default: len[c] = 8;
      endcase
      t = c;
      for (int k = 0; k < len[c]; k++) begin
        if (sc == 2) wts[c][k] = (k / 2) * 2;
        else if (sc == 3 && c == 0) wts[c][k] = 0;
        else begin
          t = t + ((k * 7 + c * 5) % 4);
          wts[c][k] = t;
        end
      end
      total += len[c];
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      ptr[c] = 0;
      m_done[c] = 1'b0;
    end
    m_ov = 1'b0;
    acc_count = 0;
    have_acc = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = '1;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == '0, "R1 ready held low in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R1 out_valid low in reset", int'(out_valid), 0);
    in_valid = '0;
    rst = 1'b0;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid low after reset", int'(out_valid), 0);
  endtask

  task automatic step(input int sc, input int cyc);
    int win, mn;
    bit elig, live, fire;
    int exp_rdy;
    // Registered outputs vs reference
    check(out_valid == m_ov, "R7 R9 out_valid", int'(out_valid), int'(m_ov));
    if (m_ov) begin
      check(int'(out_ts) == m_ts, "R3 R7 R8 out_ts", int'(out_ts), m_ts);
      check(int'(out_data) == m_data, "R3 R7 out_data", int'(out_data), m_data);
      check(int'(out_ch) == m_ch, "R3 R7 out_ch", int'(out_ch), m_ch);
      check(out_last == m_last, "R6 R7 out_last", int'(out_last), int'(m_last));
    end
    // Drive inputs
    for (int c = 0; c < N; c++) begin
      if (m_done[c]) begin
        dv[c] = (sc == 3);
        dts[c] = 0; ddata[c] = 16'hDEAD; dlast[c] = 1'b1;
      end else if (ptr[c] < len[c] && gate(sc, c, cyc)) begin
        dv[c] = 1'b1;
        dts[c] = wts[c][ptr[c]];
        ddata[c] = (c << 12) | ptr[c];
        dlast[c] = (ptr[c] == len[c] - 1);
      end else begin
        dv[c] = 1'b0; dts[c] = 0; ddata[c] = 16'hBEEF; dlast[c] = 1'b0;
      end
      in_valid[c] = dv[c];
      in_ts[c*TW +: TW] = dts[c][TW-1:0];
      in_data[c*DW +: DW] = ddata[c][DW-1:0];
      in_last[c] = dlast[c];
    end
    out_ready = rdy_pat(sc, cyc);
    #1;
    // Reference grant
    elig = 1'b1; live = 1'b0; win = -1; mn = 0;
    for (int c = 0; c < N; c++) begin
      if (!(dv[c] || m_done[c])) elig = 1'b0;
      if (dv[c] && !m_done[c]) begin
        live = 1'b1;
        if (win < 0 || dts[c] < mn) begin win = c; mn = dts[c]; end
      end
    end
    fire = elig && live && (!m_ov || out_ready);
    exp_rdy = fire ? (1 << win) : 0;
    check(int'(in_ready) == exp_rdy, "R2 R3 R5 R6 R8 in_ready", int'(in_ready), exp_rdy);
    if (out_valid && out_ready) begin
      if (have_acc)
        check(int'(out_ts) >= last_acc, "R4 accepted order", int'(out_ts), last_acc);
      last_acc = int'(out_ts);
      have_acc = 1'b1;
      acc_count++;
    end
    @(posedge clk);
    if (fire) begin
      m_ov = 1'b1;
      m_ts = dts[win]; m_data = ddata[win]; m_ch = win; m_last = dlast[win];
      ptr[win]++;
      if (dlast[win]) m_done[win] = 1'b1;
    end else if (out_ready) begin
      m_ov = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic run(input int sc);
    int cyc;
    bit all_done;
    fill(sc);
    do_reset();
    cyc = 0;
    all_done = 1'b0;
    while (!(all_done && !m_ov) && cyc < 600) begin
      step(sc, cyc);
      cyc++;
      all_done = 1'b1;
      for (int c = 0; c < N; c++) if (!m_done[c]) all_done = 1'b0;
    end
    // Flush the last held word out
    out_ready = 1'b1;
    if (out_valid) begin
      acc_count++;
      @(posedge clk);
      @(negedge clk);
    end
    check(acc_count == total, "R7 every word delivered once", acc_count, total);
    check(out_valid == 1'b0, "R9 idle after drain", int'(out_valid), 0);
  endtask

  initial begin
    run(0);  // steady flow
    run(1);  // valid gaps and output stalls
    run(2);  // timestamp ties
    run(3);  // early finish, lagging input, junk on finished inputs
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule